// File: doc/BRIEF.md
# Programmable CRC-32 Register Engine

A memory-mapped CRC accumulator on a minimal 32-bit register bus (write strobe, read strobe, byte offset, write data, read data). Software loads a seed and a generator polynomial, then writes a control word. That control word can reload the accumulator from the seed and can select reversal of the input word and of the read-back value. After that, each 32-bit write to the data register folds one whole word into the accumulator in a single clock cycle. A read of the data register returns the running CRC.

The engine works on the polynomial in normal, MSB-first form. Full-word bit reversal on the input and on the read path turns it into a reflected CRC engine. With the polynomial 0x04C11DB7 it gives the Ethernet CRC-32, and with 0x1EDC6F41 it gives CRC-32C. The block applies no final XOR; software complements the result itself.

Top module: `crc32_regport`

## Requirements
- R1: After hardware reset, the data register reads 0xFFFFFFFF, the seed register (offset 0x10) reads 0xFFFFFFFF, the polynomial register (offset 0x14) reads 0x04C11DB7 and the control register (offset 0x08) reads 0.
- R2: Writes to the seed and polynomial registers are read back unchanged, and these registers change only when written.
- R3: Writing the control register with bit 0 set loads the accumulator with the current seed register. Bit 0 always reads as 0.
- R4: A write to the data register (offset 0x00) folds all 32 bits, MSB first, into the accumulator with the programmed normal-form polynomial. A read in the next cycle shows the result.
- R5: Control bits 6:5 equal to 2'b11 bit-reverse each data word before it is folded. The values 2'b00, 2'b01 and 2'b10 fold the word as written. Both bits are stored and read back.
- R6: Control bit 7 makes a data-register read return the bit reverse of the accumulator. It changes only the read path, never the accumulator.
- R7: With reversal fully enabled (control 0xE1), seed 0xFFFFFFFF and the little-endian words 0x34333231, 0x38373635, the complemented read gives 0x9AE0DAAF for polynomial 0x04C11DB7 and 0x6087809A for polynomial 0x1EDC6F41.
- R8: Offsets other than 0x00, 0x08, 0x10 and 0x14 read as 0, and writes to them change no register.
- R9: A control write with bit 0 clear leaves the accumulator unchanged.
- R10: Read data is 0 in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from state |

## Verification
A wrong accumulator value cannot be seen directly. It shows up in the next data-register read after the faulty update, and it then corrupts every later CRC until a seed reload. A mistake in reversal or in polynomial handling appears in the first read after one data word, because a single word exercises every feedback stage. A control or decode fault appears in the read of the register it touched, or as a nonzero value at an unmapped offset.

// File: rtl/crc_regport_pkg.sv
package crc_regport_pkg;
    localparam int WORD_W = 32;
    localparam int OFF_W  = 5;

    // Software-visible byte offsets
    localparam logic [OFF_W-1:0] OFF_DATA = 5'h00;
    localparam logic [OFF_W-1:0] OFF_CTRL = 5'h08;
    localparam logic [OFF_W-1:0] OFF_SEED = 5'h10;
    localparam logic [OFF_W-1:0] OFF_POLY = 5'h14;

    // Control word bit positions
    localparam int CTL_RELOAD = 0;
    localparam int CTL_IN_LO  = 5;
    localparam int CTL_IN_HI  = 6;
    localparam int CTL_OUTREV = 7;

    localparam logic [1:0] IN_MODE_WORD = 2'b11;

    localparam logic [WORD_W-1:0] SEED_AT_RESET = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] POLY_AT_RESET = 32'h04C1_1DB7;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] seed;
        logic [WORD_W-1:0] poly;
        logic [1:0]        in_mode;
        logic              out_rev;
    } crc_regs_t;
endpackage

// File: rtl/crc_bitrev.sv
module crc_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] vec_o
);
    for (genvar g = 0; g < W; g++) begin : g_swap
        assign vec_o[g] = vec_i[W-1-g];
    end
endmodule

// File: rtl/crc_fold.sv
module crc_fold #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] poly_i,
    output logic [W-1:0] acc_o
);
    // One shift stage per data bit, MSB of the word first
    logic [W:0][W-1:0] stage;

    assign stage[0] = acc_i;

    for (genvar g = 0; g < W; g++) begin : g_step
        logic fb;
        assign fb           = stage[g][W-1] ^ data_i[W-1-g];
        assign stage[g+1]   = {stage[g][W-2:0], 1'b0} ^ (fb ? poly_i : '0);
    end

    assign acc_o = stage[W];
endmodule

// File: rtl/crc32_regport.sv
module crc32_regport
    import crc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFF_W-1:0]  addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    crc_regs_t state_d, state_q;

    logic [WORD_W-1:0] wdata_rev;
    logic [WORD_W-1:0] fold_in;
    logic [WORD_W-1:0] fold_out;
    logic [WORD_W-1:0] acc_rev;

    // Views of state used by the bound checker
    logic [WORD_W-1:0] acc_view;
    logic [WORD_W-1:0] seed_view;
    logic [WORD_W-1:0] poly_view;

    assign acc_view  = state_q.acc;
    assign seed_view = state_q.seed;
    assign poly_view = state_q.poly;

    crc_bitrev #(.W(WORD_W)) u_in_rev (
        .vec_i (wdata),
        .vec_o (wdata_rev)
    );

    assign fold_in = (state_q.in_mode == IN_MODE_WORD) ? wdata_rev : wdata;

    crc_fold #(.W(WORD_W)) u_fold (
        .acc_i  (state_q.acc),
        .data_i (fold_in),
        .poly_i (state_q.poly),
        .acc_o  (fold_out)
    );

    crc_bitrev #(.W(WORD_W)) u_out_rev (
        .vec_i (state_q.acc),
        .vec_o (acc_rev)
    );

    always_comb begin
        state_d = state_q;
        rdata   = '0;

        if (wr_en) begin
            unique case (addr)
                OFF_DATA: state_d.acc = fold_out;
                OFF_CTRL: begin
                    state_d.in_mode = wdata[CTL_IN_HI:CTL_IN_LO];
                    state_d.out_rev = wdata[CTL_OUTREV];
                    if (wdata[CTL_RELOAD]) begin
                        state_d.acc = state_q.seed;
                    end
                end
                OFF_SEED: state_d.seed = wdata;
                OFF_POLY: state_d.poly = wdata;
                default: ;
            endcase
        end

        if (rd_en) begin
            unique case (addr)
                OFF_DATA: rdata = state_q.out_rev ? acc_rev : state_q.acc;
                OFF_CTRL: begin
                    rdata[CTL_IN_HI:CTL_IN_LO] = state_q.in_mode;
                    rdata[CTL_OUTREV]          = state_q.out_rev;
                end
                OFF_SEED: rdata = state_q.seed;
                OFF_POLY: rdata = state_q.poly;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.acc     <= SEED_AT_RESET;
            state_q.seed    <= SEED_AT_RESET;
            state_q.poly    <= POLY_AT_RESET;
            state_q.in_mode <= 2'b00;
            state_q.out_rev <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/crc32_regport_chk.sv
module crc32_regport_chk
    import crc_regport_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [OFF_W-1:0]  addr,
    input logic [WORD_W-1:0] wdata,
    input logic [WORD_W-1:0] rdata,
    input logic [WORD_W-1:0] acc,
    input logic [WORD_W-1:0] seed,
    input logic [WORD_W-1:0] poly
);
    logic mapped;
    assign mapped = (addr == OFF_DATA) || (addr == OFF_CTRL) ||
                    (addr == OFF_SEED) || (addr == OFF_POLY);

    assert_reload_loads_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CTRL && wdata[CTL_RELOAD]) |=> (acc == $past(seed)));

    assert_reload_bit_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFF_CTRL) |-> (rdata[CTL_RELOAD] == 1'b0));

    assert_acc_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == OFF_DATA || (addr == OFF_CTRL && wdata[CTL_RELOAD])))
        |=> $stable(acc));

    assert_poly_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFF_POLY) |=> $stable(poly));

    assert_seed_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFF_SEED) |=> $stable(seed));

    assert_unmapped_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |-> (rdata == '0));

    assert_idle_bus_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

bind crc32_regport crc32_regport_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .acc   (acc_view),
    .seed  (seed_view),
    .poly  (poly_view)
);

// File: tb/crc32_regport_bench.sv
`timescale 1ns/1ps
module crc32_regport_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    crc32_regport u_crc32_regport (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Bench model of the requirements
    logic [31:0] m_acc, m_seed, m_poly;
    logic [1:0]  m_in;
    logic        m_out;

    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [31:0] fold_msb(input logic [31:0] c, input logic [31:0] d,
                                             input logic [31:0] p);
        logic [31:0] x = c;
        for (int i = 31; i >= 0; i--) begin
            if (x[31] ^ d[i]) x = (x << 1) ^ p;
            else              x = x << 1;
        end
        return x;
    endfunction

    // Byte-serial reflected software CRC, independent of word folding
    function automatic logic [31:0] soft_reflected(input logic [31:0] rpoly, input logic [63:0] msg);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < 8; b++) begin
            c = c ^ {24'h0, msg[8*b +: 8]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ rpoly) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [31:0] model_read();
        return m_out ? rev32(m_acc) : m_acc;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
        // Update the model
        case (a)
            5'h00: m_acc = fold_msb(m_acc, (m_in == 2'b11) ? rev32(v) : v, m_poly);
            5'h08: begin
                m_in = v[6:5]; m_out = v[7];
                if (v[0]) m_acc = m_seed;
            end
            5'h10: m_seed = v;
            5'h14: m_poly = v;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, a_val, msg_lo, msg_hi;
        void'($urandom(32'h1234_5678));
        m_acc = 32'hFFFF_FFFF; m_seed = 32'hFFFF_FFFF; m_poly = 32'h04C1_1DB7;
        m_in = 2'b00; m_out = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        rd(5'h00, v); check("R1 data", v, 32'hFFFF_FFFF);
        rd(5'h10, v); check("R1 seed", v, 32'hFFFF_FFFF);
        rd(5'h14, v); check("R1 poly", v, 32'h04C1_1DB7);
        rd(5'h08, v); check("R1 ctrl", v, 32'h0);

        // R10 idle bus
        @(negedge clk); addr = 5'h10; #1 check("R10 idle rdata", rdata, 32'h0);

        // R2 register readback
        wr(5'h10, 32'hA5A5_0F0F); rd(5'h10, v); check("R2 seed", v, 32'hA5A5_0F0F);
        wr(5'h14, 32'h1EDC_6F41); rd(5'h14, v); check("R2 poly", v, 32'h1EDC_6F41);

        // R3 reload and read of bit 0
        wr(5'h08, 32'h0000_0061); rd(5'h00, v); check("R3 reload", v, 32'hA5A5_0F0F);
        rd(5'h08, v); check("R3 ctrl read", v, 32'h0000_0060);

        // R5 input reversal, R4 fold
        wr(5'h00, 32'hDEAD_BEEF); rd(5'h00, v); check("R5 word reversed fold", v, model_read());

        // R6 output reversal alters read only; R9 no reload
        rd(5'h00, a_val);
        wr(5'h08, 32'h0000_00E0); rd(5'h00, v); check("R6 out reversed", v, rev32(a_val));
        wr(5'h08, 32'h0000_0060); rd(5'h00, v); check("R9 acc kept", v, a_val);

        // R5 modes 01 and 10 fold as written
        wr(5'h08, 32'h0000_0021); wr(5'h00, 32'h0123_4567); rd(5'h00, v);
        check("R5 mode 01", v, model_read());
        wr(5'h08, 32'h0000_0041); wr(5'h00, 32'h89AB_CDEF); rd(5'h00, v);
        check("R5 mode 10", v, model_read());

        // R8 unmapped offsets
        rd(5'h00, a_val);
        wr(5'h04, 32'hFFFF_FFFF); wr(5'h18, 32'h1234_5678); wr(5'h0C, 32'h0000_00E1);
        rd(5'h04, v); check("R8 read 0x04", v, 32'h0);
        rd(5'h1C, v); check("R8 read 0x1C", v, 32'h0);
        rd(5'h00, v); check("R8 acc untouched", v, a_val);
        rd(5'h10, v); check("R8 seed untouched", v, 32'hA5A5_0F0F);
        rd(5'h14, v); check("R8 poly untouched", v, 32'h1EDC_6F41);
        rd(5'h08, v); check("R8 ctrl untouched", v, 32'h0000_0040);

        // R7 known check values
        msg_lo = 32'h3433_3231; msg_hi = 32'h3837_3635;
        wr(5'h10, 32'hFFFF_FFFF); wr(5'h14, 32'h04C1_1DB7); wr(5'h08, 32'h0000_00E1);
        wr(5'h00, msg_lo); wr(5'h00, msg_hi); rd(5'h00, v);
        check("R7 crc32", ~v, 32'h9AE0_DAAF);
        check("R7 crc32 soft", ~v, soft_reflected(32'hEDB8_8320, {msg_hi, msg_lo}));
        wr(5'h14, 32'h1EDC_6F41); wr(5'h08, 32'h0000_00E1);
        wr(5'h00, msg_lo); wr(5'h00, msg_hi); rd(5'h00, v);
        check("R7 crc32c", ~v, 32'h6087_809A);
        check("R7 crc32c soft", ~v, soft_reflected(32'h82F6_3B78, {msg_hi, msg_lo}));

        // R4 and R5 random streams
        for (int t = 0; t < 60; t++) begin
            wr(5'h10, $urandom());
            wr(5'h14, $urandom() | 32'h1);
            wr(5'h08, ($urandom() & 32'h0000_00E0) | 32'h1);
            rd(5'h00, v); check("R3 random reload", v, model_read());
            for (int k = 0; k < 1 + ($urandom() % 6); k++) begin
                wr(5'h00, $urandom());
                rd(5'h00, v); check("R4 random fold", v, model_read());
            end
        end

        done = 1;
        finish_run();
    end
endmodule